// File: doc/BRIEF.md
# Half-Turn Display Buffer Rotator

This block hands out display buffers to the two LED panel drivers of a spinning display. Each half-frame slice has to be shown twice, once by each half of the panel, so that it can be seen from every viewing angle. In the default shared mode three half-turn-sized buffers serve both drivers. At every half-turn boundary the buffers move one step around a ring. The first driver takes over the buffer the second driver has just shown. The second driver takes the freshly filled spare buffer. The first driver's old buffer becomes the new spare. The block then asks an external DMA engine to refill that spare with the next slice. New data therefore only ever enters through the second driver, and each slice is stored once but shown twice.

If the spare has not been reported full when a half-turn boundary arrives, the block does not hand out an unfilled buffer. It flags an underrun, leaves the second driver where it is and points the first driver at the same buffer. The flag stays up until the next boundary that finds the spare full.

A parameter selects a fallback mode for systems that cannot share buffers. In that mode there are two full-turn buffers used as a ping-pong pair. Both drivers read the one being displayed, and the other is refilled. The swap happens every second half-turn strobe, which costs about a third more storage than the shared ring.

The control is a four-state machine. FILL means a refill is pending. READY means the spare is full. STARVE means an underrun happened and the refill is still pending. RECOVER means an underrun happened and the spare is now full. The transitions are:
- FILL to READY on fill-done.
- FILL to FILL (rotate) on a boundary that coincides with fill-done.
- FILL to STARVE on a boundary without fill-done.
- READY to FILL (rotate) on a boundary.
- STARVE to RECOVER on fill-done.
- STARVE to FILL (rotate) on a boundary with fill-done.
- STARVE to STARVE on a boundary without fill-done.
- RECOVER to FILL (rotate) on a boundary.

Top module: `halfturn_buf_alloc`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after reset the shared mode gives the first driver index 0 and the second driver index 1, and shows spare index 2 with fill_req_o high and underrun_o low. Indices are plain binary values 0, 1 and 2.
- R2: In shared mode, whenever underrun_o is low, the first driver index, the second driver index and the spare index are three distinct values from {0,1,2}.
- R3: In shared mode, a half-turn strobe that finds the spare full, with underrun_o low, gives the following in the next cycle: the first driver gets the old second driver index, the second driver gets the old spare index, and the spare index becomes the old first driver index.
- R4: After every rotation fill_req_o is high, with the spare index held, until a fill_done_i pulse arrives. fill_req_o is low in the cycle after that pulse.
- R5: A fill_done_i pulse in the same cycle as a half-turn strobe counts as a full spare, so the strobe rotates.
- R6: A fill_done_i pulse while fill_req_o is low has no effect on any output.
- R7: In shared mode, a strobe while fill_req_o is high and fill_done_i is low sets underrun_o in the next cycle. The second driver keeps its index, the first driver takes the same index, and fill_req_o and the spare index are unchanged.
- R8: underrun_o stays high until the next strobe that finds the spare full. That strobe rotates and clears it, and the new spare index is the one that neither the second driver nor the old spare was using.
- R9: In fallback mode (SHARE_EN = 0), after reset both drivers use index 0 and the spare is index 1. Both drivers always share one index that differs from the spare. The swap happens only on every second strobe (the first strobe after reset does not swap), and an unfilled spare at a swap strobe raises underrun_o without changing the indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_turn_i | input | 1 | One-cycle strobe at each half-turn boundary |
| fill_done_i | input | 1 | One-cycle pulse: the spare buffer has been filled |
| drv_a_idx_o | output | 2 | Buffer index for the first driver |
| drv_b_idx_o | output | 2 | Buffer index for the second driver |
| fill_idx_o | output | 2 | Index of the spare buffer to be refilled |
| fill_req_o | output | 1 | Refill of fill_idx_o requested |
| underrun_o | output | 1 | A boundary arrived before the spare was filled |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default shared ring, and the other uses SHARE_EN = 0. The shared copy reaches every rotation, starvation and recovery path of the index ring. The fallback copy reaches the half-turn parity and the full-turn ping-pong swap. The stimulus mixes timely refills, coincident refill and strobe, spurious refills, back-to-back starved strobes and a long pseudo-random stretch. Both copies see the same sequence, so the two underrun rules are compared under identical timing.

// File: rtl/hta_pkg.sv
package hta_pkg;
    localparam int HTA_NUM_BUFS = 3;
    localparam int HTA_IDX_W    = 2;

    typedef logic [HTA_IDX_W-1:0] buf_idx_t;

    typedef enum logic [1:0] {
        ST_FILL    = 2'd0,
        ST_READY   = 2'd1,
        ST_STARVE  = 2'd2,
        ST_RECOVER = 2'd3
    } hta_state_e;
endpackage

// File: rtl/hta_fill_fsm.sv
module hta_fill_fsm
    import hta_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic boundary_i,
    input  logic fill_done_i,
    output logic advance_o,
    output logic starve_o,
    output logic fill_req_o,
    output logic underrun_o
);
    hta_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and the per-cycle ring commands
    always_comb begin
        state_d   = state_q;
        advance_o = 1'b0;
        starve_o  = 1'b0;
        unique case (state_q)
            ST_FILL, ST_STARVE: begin
                if (boundary_i && fill_done_i) begin
                    advance_o = 1'b1;
                    state_d   = ST_FILL;
                end else if (boundary_i) begin
                    starve_o  = 1'b1;
                    state_d   = ST_STARVE;
                end else if (fill_done_i) begin
                    state_d   = (state_q == ST_FILL) ? ST_READY : ST_RECOVER;
                end
            end
            ST_READY, ST_RECOVER: begin
                if (boundary_i) begin
                    advance_o = 1'b1;
                    state_d   = ST_FILL;
                end
            end
            default: state_d = ST_FILL;
        endcase
    end

    // Moore outputs
    always_comb begin
        fill_req_o = 1'b0;
        underrun_o = 1'b0;
        unique case (state_q)
            ST_FILL:    fill_req_o = 1'b1;
            ST_READY:   ;
            ST_STARVE: begin
                fill_req_o = 1'b1;
                underrun_o = 1'b1;
            end
            ST_RECOVER: underrun_o = 1'b1;
            default:    fill_req_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/hta_ring_index.sv
module hta_ring_index
    import hta_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     advance_i,
    input  logic     starve_i,
    output buf_idx_t drv_a_o,
    output buf_idx_t drv_b_o,
    output buf_idx_t spare_o
);
    buf_idx_t a_q, b_q, s_q;
    buf_idx_t unused_idx;

    // index held by neither the second driver nor the current spare
    always_comb begin
        unused_idx = '0;
        for (int k = HTA_NUM_BUFS - 1; k >= 0; k--) begin
            if (buf_idx_t'(k) != b_q && buf_idx_t'(k) != s_q) begin
                unused_idx = buf_idx_t'(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= buf_idx_t'(0);
            b_q <= buf_idx_t'(1);
            s_q <= buf_idx_t'(2);
        end else if (advance_i) begin
            a_q <= b_q;
            b_q <= s_q;
            s_q <= unused_idx;
        end else if (starve_i) begin
            a_q <= b_q;
        end
    end

    assign drv_a_o = a_q;
    assign drv_b_o = b_q;
    assign spare_o = s_q;
endmodule

// File: rtl/hta_pingpong_index.sv
module hta_pingpong_index
    import hta_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     half_turn_i,
    input  logic     advance_i,
    output logic     boundary_o,
    output buf_idx_t show_o,
    output buf_idx_t spare_o
);
    logic     second_half_q;
    buf_idx_t show_q, spare_q;

    // a full turn ends on every second half-turn strobe
    assign boundary_o = half_turn_i && second_half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            second_half_q <= 1'b0;
            show_q        <= buf_idx_t'(0);
            spare_q       <= buf_idx_t'(1);
        end else begin
            if (half_turn_i) begin
                second_half_q <= ~second_half_q;
            end
            if (advance_i) begin
                show_q  <= spare_q;
                spare_q <= show_q;
            end
        end
    end

    assign show_o  = show_q;
    assign spare_o = spare_q;
endmodule

// File: rtl/halfturn_buf_alloc.sv
module halfturn_buf_alloc
    import hta_pkg::*;
#(
    parameter bit SHARE_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 half_turn_i,
    input  logic                 fill_done_i,
    output logic [HTA_IDX_W-1:0] drv_a_idx_o,
    output logic [HTA_IDX_W-1:0] drv_b_idx_o,
    output logic [HTA_IDX_W-1:0] fill_idx_o,
    output logic                 fill_req_o,
    output logic                 underrun_o
);
    logic boundary;
    logic advance;
    logic starve;

    hta_fill_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .boundary_i  (boundary),
        .fill_done_i (fill_done_i),
        .advance_o   (advance),
        .starve_o    (starve),
        .fill_req_o  (fill_req_o),
        .underrun_o  (underrun_o)
    );

    generate
        if (SHARE_EN) begin : g_ring
            assign boundary = half_turn_i;
            hta_ring_index u_ring (
                .clk       (clk),
                .rst       (rst),
                .advance_i (advance),
                .starve_i  (starve),
                .drv_a_o   (drv_a_idx_o),
                .drv_b_o   (drv_b_idx_o),
                .spare_o   (fill_idx_o)
            );
        end else begin : g_pingpong
            buf_idx_t show_idx;
            logic     starve_unused;
            assign starve_unused = starve;
            hta_pingpong_index u_pp (
                .clk         (clk),
                .rst         (rst),
                .half_turn_i (half_turn_i),
                .advance_i   (advance),
                .boundary_o  (boundary),
                .show_o      (show_idx),
                .spare_o     (fill_idx_o)
            );
            assign drv_a_idx_o = show_idx;
            assign drv_b_idx_o = show_idx;
        end
    endgenerate
endmodule

// File: rtl/hta_checker.sv
module hta_checker
    import hta_pkg::*;
#(
    parameter bit SHARE_EN = 1'b1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 half_turn_i,
    input logic                 fill_done_i,
    input logic [HTA_IDX_W-1:0] drv_a_idx_o,
    input logic [HTA_IDX_W-1:0] drv_b_idx_o,
    input logic [HTA_IDX_W-1:0] fill_idx_o,
    input logic                 fill_req_o,
    input logic                 underrun_o
);
    p_fill_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (fill_req_o && !fill_done_i && !half_turn_i)
        |=> (fill_req_o && $stable(fill_idx_o)));

    p_done_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (fill_req_o && fill_done_i && !half_turn_i) |=> !fill_req_o);

    p_spurious_done_r6: assert property (@(posedge clk) disable iff (rst)
        (!fill_req_o && fill_done_i && !half_turn_i)
        |=> ($stable(drv_a_idx_o) && $stable(drv_b_idx_o)
             && $stable(fill_idx_o) && $stable(underrun_o) && !fill_req_o));

    p_underrun_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (underrun_o && !half_turn_i) |=> underrun_o);

    generate
        if (SHARE_EN) begin : g_shared_props
            p_reset_map_r1: assert property (@(posedge clk)
                rst |=> (rst || (drv_a_idx_o == 2'd0 && drv_b_idx_o == 2'd1
                                 && fill_idx_o == 2'd2 && fill_req_o && !underrun_o)));

            p_perm_r2: assert property (@(posedge clk) disable iff (rst)
                !underrun_o |-> (drv_a_idx_o != drv_b_idx_o && drv_a_idx_o != fill_idx_o
                                 && drv_b_idx_o != fill_idx_o && drv_a_idx_o < 2'd3
                                 && drv_b_idx_o < 2'd3 && fill_idx_o < 2'd3));

            p_rotate_r3: assert property (@(posedge clk) disable iff (rst)
                (half_turn_i && !underrun_o && (!fill_req_o || fill_done_i))
                |=> (drv_a_idx_o == $past(drv_b_idx_o) && drv_b_idx_o == $past(fill_idx_o)
                     && fill_idx_o == $past(drv_a_idx_o) && fill_req_o && !underrun_o));

            p_starve_r7: assert property (@(posedge clk) disable iff (rst)
                (half_turn_i && fill_req_o && !fill_done_i)
                |=> (underrun_o && fill_req_o && drv_b_idx_o == $past(drv_b_idx_o)
                     && drv_a_idx_o == $past(drv_b_idx_o) && $stable(fill_idx_o)));
        end else begin : g_pp_props
            p_shared_show_r9: assert property (@(posedge clk) disable iff (rst)
                (drv_a_idx_o == drv_b_idx_o && drv_a_idx_o != fill_idx_o));
        end
    endgenerate
endmodule

bind halfturn_buf_alloc hta_checker #(.SHARE_EN(SHARE_EN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .half_turn_i (half_turn_i),
    .fill_done_i (fill_done_i),
    .drv_a_idx_o (drv_a_idx_o),
    .drv_b_idx_o (drv_b_idx_o),
    .fill_idx_o  (fill_idx_o),
    .fill_req_o  (fill_req_o),
    .underrun_o  (underrun_o)
);

// File: tb/halfturn_buf_alloc_tb.sv
module halfturn_buf_alloc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic half_turn = 1'b0;
    logic fill_done = 1'b0;

    logic [1:0] s_a, s_b, s_f;
    logic       s_req, s_und;
    logic [1:0] p_a, p_b, p_f;
    logic       p_req, p_und;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";
    bit started = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    halfturn_buf_alloc #(.SHARE_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .half_turn_i(half_turn), .fill_done_i(fill_done),
        .drv_a_idx_o(s_a), .drv_b_idx_o(s_b), .fill_idx_o(s_f),
        .fill_req_o(s_req), .underrun_o(s_und));

    halfturn_buf_alloc #(.SHARE_EN(1'b0)) u_dut_pp (
        .clk(clk), .rst(rst), .half_turn_i(half_turn), .fill_done_i(fill_done),
        .drv_a_idx_o(p_a), .drv_b_idx_o(p_b), .fill_idx_o(p_f),
        .fill_req_o(p_req), .underrun_o(p_und));

    // behavioural reference: shared ring
    int m_a, m_b, m_f;
    bit m_full, m_und;
    // behavioural reference: full-turn ping-pong
    int q_show, q_spare;
    bit q_odd, q_full, q_und;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_a = 0; m_b = 1; m_f = 2; m_full = 0; m_und = 0;
            q_show = 0; q_spare = 1; q_odd = 0; q_full = 0; q_und = 0;
        end else begin
            if (half_turn) begin
                if (m_full || fill_done) begin
                    int old_a;
                    old_a = m_a;
                    m_a = m_b; m_b = m_f; m_f = 3 - m_a - m_b;
                    if (m_und == 0 && m_f != old_a) m_f = -1;
                    m_full = 0; m_und = 0;
                end else begin
                    m_a = m_b; m_und = 1;
                end
            end else if (fill_done) begin
                m_full = 1;
            end

            if (half_turn && q_odd) begin
                if (q_full || fill_done) begin
                    int t;
                    t = q_show; q_show = q_spare; q_spare = t;
                    q_full = 0; q_und = 0;
                end else begin
                    q_und = 1;
                end
            end else if (fill_done) begin
                q_full = 1;
            end
            if (half_turn) q_odd = !q_odd;
        end
    end

    task automatic chk(input int act, input int exp, input string req, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !rst && !done_flag) begin
            chk(s_a, m_a, cur_req, "shared drv_a");
            chk(s_b, m_b, cur_req, "shared drv_b");
            chk(s_f, m_f, cur_req, "shared fill_idx");
            chk(s_req, !m_full, cur_req, "shared fill_req");
            chk(s_und, m_und, cur_req, "shared underrun");
            chk(p_a, q_show, "R9", "pp drv_a");
            chk(p_b, q_show, "R9", "pp drv_b");
            chk(p_f, q_spare, "R9", "pp fill_idx");
            chk(p_req, !q_full, "R9", "pp fill_req");
            chk(p_und, q_und, "R9", "pp underrun");
        end
    end

    task automatic cyc(input bit h, input bit d);
        half_turn = h;
        fill_done = d;
        @(negedge clk);
        half_turn = 1'b0;
        fill_done = 1'b0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        int lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset map
        cur_req = "R1";
        chk(s_a, 0, "R1", "reset drv_a");
        chk(s_b, 1, "R1", "reset drv_b");
        chk(s_f, 2, "R1", "reset fill_idx");
        chk(s_req, 1, "R1", "reset fill_req");
        chk(s_und, 0, "R1", "reset underrun");
        chk(p_a, 0, "R9", "reset pp drv_a");
        chk(p_f, 1, "R9", "reset pp fill_idx");
        // R4 request held until done
        cur_req = "R4";
        cyc(0, 0); cyc(0, 0);
        chk(s_req, 1, "R4", "request held");
        cyc(0, 1);
        chk(s_req, 0, "R4", "request dropped after done");
        // R6 spurious done
        cur_req = "R6";
        cyc(0, 1);
        chk(s_req, 0, "R6", "spurious done fill_req");
        chk(s_f, 2, "R6", "spurious done fill_idx");
        // R3 rotation
        cur_req = "R3";
        cyc(1, 0);
        chk(s_a, 1, "R3", "rotate drv_a");
        chk(s_b, 2, "R3", "rotate drv_b");
        chk(s_f, 0, "R3", "rotate fill_idx");
        // R2 several clean rounds
        cur_req = "R2";
        for (int i = 0; i < 6; i++) begin
            cyc(0, 0); cyc(0, 1); cyc(0, 0); cyc(1, 0);
        end
        // R5 coincident strobe and done
        cur_req = "R5";
        cyc(1, 1);
        chk(s_und, 0, "R5", "coincident done no underrun");
        cyc(0, 0);
        // R7 strobe without fill, twice
        cur_req = "R7";
        cyc(1, 0);
        chk(s_und, 1, "R7", "underrun raised");
        chk(s_a, s_b, "R7", "drv_a copies drv_b");
        cyc(0, 0);
        cyc(1, 0);
        cyc(1, 0);
        // R8 recovery
        cur_req = "R8";
        cyc(0, 1);
        cyc(0, 0);
        chk(s_und, 1, "R8", "underrun held until strobe");
        cyc(1, 0);
        chk(s_und, 0, "R8", "underrun cleared");
        chk((s_a != s_b && s_b != s_f && s_a != s_f) ? 1 : 0, 1, "R8", "distinct after recovery");
        // starve then recover through coincident done
        cyc(1, 0);
        cyc(1, 1);
        // pseudo-random stretch
        cur_req = "R2";
        lfsr = 32'h1d2c;
        for (int i = 0; i < 400; i++) begin
            lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
            cyc(((lfsr >> 8) % 5) == 0, ((lfsr >> 16) % 3) == 0);
        end
        // reset mid-run returns to R1 map
        cur_req = "R1";
        rst = 1'b1;
        cyc(1, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(s_f, 2, "R1", "second reset fill_idx");
        chk(p_f, 1, "R9", "second reset pp fill_idx");
        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule